// File: doc/BRIEF.md
# Keyboard Controller Command Sequencer

This block runs one complete command exchange with an 8-bit keyboard-controller register port. The port has a status register, a command register and a data register. A start pulse hands the block a 16-bit command word and a parameter buffer. The block first writes the opcode to the command register. It then writes the parameter bytes to the data register, and then reads the response bytes back into the same buffer. Finally it reports success or failure.

The command word carries the transfer counts. Bits 7:0 hold the opcode, bits 15:12 the number of parameter bytes and bits 11:8 the number of response bytes. Every register access waits for a handshake flag in the status register. The flag is polled only in cycles where a tick-enable input is high. A run of unready polls aborts the exchange.

The loopback opcode gets extra treatment. Each byte it reads back must carry the auxiliary-source flag. A configuration input can also refuse the loopback opcode outright.

Top module: `kbc_cmd_seq`

## Requirements
- R1: An accepted start writes the opcode (command word bits 7:0) exactly once, through `cmd_we_o`, and before any data-register access.
- R2: After the opcode, the block writes N parameter bytes through `data_we_o`, where N is command word bits 15:12. They come from buffer slots 0, 1, … N-1, in that order.
- R3: After the parameters, the block reads M response bytes through `data_rd_o`, where M is bits 11:8. Read k (counting from 0) overwrites slot k. The buffer is loaded from `param_i` at start, and slots not overwritten keep their loaded values.
- R4: A write is issued only after a tick cycle in which status bit 1 (input buffer full) was clear. A read is issued only after a tick cycle in which status bit 0 (output buffer full) was set. Status is sampled only in tick cycles.
- R5: If TIMEOUT_POLLS consecutive tick polls of one wait find the port not ready, the exchange ends with `err_o`. No further strobe is issued.
- R6: With opcode 0xD3 (loopback), a ready read whose status bit 5 (auxiliary source) is clear ends the exchange with `err_o`. No read strobe is issued and the buffer is not written.
- R7: While `no_loop_i` is high, a start with opcode 0xD3 issues no strobe. Busy stays high for one cycle and then `err_o` pulses. Other opcodes run normally.
- R8: `busy_o` rises the cycle after an accepted start and stays high until the cycle in which `done_o` or `err_o` pulses. In that cycle `busy_o` is low. Each result pulse lasts one cycle, and a start while busy is ignored.
- R9: Each strobe lasts one cycle and comes in the cycle after the ready poll. After the last strobe, `done_o` pulses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an exchange (ignored while busy) |
| cmd_word_i | input | 16 | Parameter count, response count, opcode |
| param_i | input | 8*SLOTS | Initial buffer contents, slot k at bits 8k+7:8k |
| no_loop_i | input | 1 | Refuse the loopback opcode |
| tick_i | input | 1 | Poll enable |
| stat_i | input | 8 | Controller status register value |
| rdata_i | input | 8 | Controller data register value |
| cmd_we_o | output | 1 | Command register write strobe |
| data_we_o | output | 1 | Data register write strobe |
| wdata_o | output | 8 | Write data for either register |
| data_rd_o | output | 1 | Data register read strobe |
| buf_o | output | 8*SLOTS | Buffer contents |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |

## Verification
Busy rises one cycle after start. A strobe appears one cycle after the tick poll that found the port ready. Done follows one cycle after the last strobe. A failure pulse comes in the cycle after the last failing poll, or in the second cycle after a refused start. The bench models the controller port and a behavioural predictor clocked on the same edges. It compares strobes, busy, result pulses and every buffer slot on each falling edge, so that every result is checked in the exact cycle it is due. Per-exchange checks then compare busy-cycle counts, the order of written bytes and final buffer contents with hand-derived values. Sparse ticks and a stuck handshake flag are among the cases.

// File: rtl/kbc_seq_pkg.sv
package kbc_seq_pkg;
  localparam int unsigned CNT_W = 4;

  typedef struct packed {
    logic [CNT_W-1:0] n_par;
    logic [CNT_W-1:0] n_rsp;
    logic [7:0]       opcode;
  } cmd_word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REFUSE,
    ST_WAIT_WR,
    ST_PUT_CMD,
    ST_PUT_PAR,
    ST_WAIT_RD,
    ST_GET_RSP
  } seq_state_e;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_seq_pkg::*;
#(
  parameter logic [7:0] LOOP_OP = 8'hD3
) (
  input  logic [15:0]      cmd_word_i,
  input  logic             no_loop_i,
  output logic [7:0]       opcode_o,
  output logic [CNT_W-1:0] n_par_o,
  output logic [CNT_W-1:0] n_rsp_o,
  output logic             is_loop_o,
  output logic             refuse_o
);
  cmd_word_t w;
  assign w         = cmd_word_t'(cmd_word_i);
  assign opcode_o  = w.opcode;
  assign n_par_o   = w.n_par;
  assign n_rsp_o   = w.n_rsp;
  assign is_loop_o = (w.opcode == LOOP_OP);
  assign refuse_o  = is_loop_o && no_loop_i;
endmodule

// File: rtl/kbc_poll_timer.sv
module kbc_poll_timer #(
  parameter int unsigned LIMIT = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic miss_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  // last permitted miss ends the wait
  assign expire_o = miss_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (miss_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/kbc_byte_buf.sv
module kbc_byte_buf #(
  parameter int unsigned SLOTS = 15,
  parameter int unsigned IDX_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SLOTS*8-1:0] load_data_i,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [7:0]         rd_data_o,
  output logic [SLOTS*8-1:0] flat_o
);
  logic [7:0] slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[s] <= '0;
      else if (load_i)                             slot_q[s] <= load_data_i[s*8 +: 8];
      else if (wr_i && (wr_idx_i == IDX_W'(s)))    slot_q[s] <= wr_data_i;
    end
    assign flat_o[s*8 +: 8] = slot_q[s];
  end

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (rd_idx_i == IDX_W'(s)) rd_data_o = slot_q[s];
    end
  end
endmodule

// File: rtl/kbc_cmd_seq.sv
module kbc_cmd_seq
  import kbc_seq_pkg::*;
#(
  parameter int unsigned SLOTS         = 15,
  parameter int unsigned TIMEOUT_POLLS = 10000,
  parameter logic [7:0]  LOOP_OP       = 8'hD3,
  parameter int unsigned OBF_BIT       = 0,
  parameter int unsigned IBF_BIT       = 1,
  parameter int unsigned AUX_BIT       = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [15:0]        cmd_word_i,
  input  logic [SLOTS*8-1:0] param_i,
  input  logic               no_loop_i,
  input  logic               tick_i,
  input  logic [7:0]         stat_i,
  input  logic [7:0]         rdata_i,
  output logic               cmd_we_o,
  output logic               data_we_o,
  output logic [7:0]         wdata_o,
  output logic               data_rd_o,
  output logic [SLOTS*8-1:0] buf_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int unsigned IDX_W = CNT_W;

  seq_state_e       state_q;
  logic [7:0]       op_q;
  logic [CNT_W-1:0] npar_q, nrsp_q, idx_q;
  logic             loop_q, cmd_sent_q, done_q, err_q;

  logic [7:0]       dec_op;
  logic [CNT_W-1:0] dec_npar, dec_nrsp;
  logic             dec_loop, dec_refuse;

  kbc_cmd_decode #(.LOOP_OP(LOOP_OP)) u_dec (
    .cmd_word_i (cmd_word_i),
    .no_loop_i  (no_loop_i),
    .opcode_o   (dec_op),
    .n_par_o    (dec_npar),
    .n_rsp_o    (dec_nrsp),
    .is_loop_o  (dec_loop),
    .refuse_o   (dec_refuse)
  );

  logic in_wait, ready, poll, hit, miss, expire, aux_bad;
  assign in_wait = (state_q == ST_WAIT_WR) || (state_q == ST_WAIT_RD);
  assign ready   = (state_q == ST_WAIT_WR) ? !stat_i[IBF_BIT] : stat_i[OBF_BIT];
  assign poll    = in_wait && tick_i;
  assign hit     = poll && ready;
  assign miss    = poll && !ready;
  assign aux_bad = (state_q == ST_WAIT_RD) && loop_q && !stat_i[AUX_BIT];

  kbc_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!in_wait),
    .miss_i   (miss),
    .expire_o (expire)
  );

  logic             accept;
  logic [7:0]       buf_rd_byte;
  logic [CNT_W:0]   nxt_idx;
  logic             more_par, more_rsp, has_rsp;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign nxt_idx  = {1'b0, idx_q} + 1'b1;
  assign has_rsp  = (nrsp_q != '0);
  assign more_par = (state_q == ST_PUT_CMD) ? (npar_q != '0)
                                            : (nxt_idx < {1'b0, npar_q});
  assign more_rsp = nxt_idx < {1'b0, nrsp_q};

  kbc_byte_buf #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_data_i (param_i),
    .wr_i        (state_q == ST_GET_RSP),
    .wr_idx_i    (idx_q),
    .wr_data_i   (rdata_i),
    .rd_idx_i    (idx_q),
    .rd_data_o   (buf_rd_byte),
    .flat_o      (buf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= '0;
      npar_q     <= '0;
      nrsp_q     <= '0;
      idx_q      <= '0;
      loop_q     <= 1'b0;
      cmd_sent_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          op_q       <= dec_op;
          npar_q     <= dec_npar;
          nrsp_q     <= dec_nrsp;
          loop_q     <= dec_loop;
          idx_q      <= '0;
          cmd_sent_q <= 1'b0;
          state_q    <= dec_refuse ? ST_REFUSE : ST_WAIT_WR;
        end
        ST_REFUSE: begin
          state_q <= ST_IDLE;
          err_q   <= 1'b1;
        end
        ST_WAIT_WR: begin
          if (hit)         state_q <= cmd_sent_q ? ST_PUT_PAR : ST_PUT_CMD;
          else if (expire) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end
        end
        ST_PUT_CMD, ST_PUT_PAR: begin
          cmd_sent_q <= 1'b1;
          if (more_par) begin
            state_q <= ST_WAIT_WR;
            idx_q   <= (state_q == ST_PUT_CMD) ? '0 : nxt_idx[CNT_W-1:0];
          end else if (has_rsp) begin
            state_q <= ST_WAIT_RD;
            idx_q   <= '0;
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_WAIT_RD: begin
          if (hit) begin
            if (aux_bad) begin
              state_q <= ST_IDLE;
              err_q   <= 1'b1;
            end else begin
              state_q <= ST_GET_RSP;
            end
          end else if (expire) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end
        end
        ST_GET_RSP: begin
          if (more_rsp) begin
            state_q <= ST_WAIT_RD;
            idx_q   <= nxt_idx[CNT_W-1:0];
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_we_o  = (state_q == ST_PUT_CMD);
  assign data_we_o = (state_q == ST_PUT_PAR);
  assign data_rd_o = (state_q == ST_GET_RSP);
  assign wdata_o   = cmd_we_o ? op_q : (data_we_o ? buf_rd_byte : 8'h00);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/kbc_cmd_seq_chk.sv
module kbc_cmd_seq_chk #(
  parameter logic [7:0]  LOOP_OP = 8'hD3,
  parameter int unsigned OBF_BIT = 0,
  parameter int unsigned IBF_BIT = 1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [15:0] cmd_word_i,
  input logic        no_loop_i,
  input logic [7:0]  stat_i,
  input logic        cmd_we_o,
  input logic        data_we_o,
  input logic        data_rd_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_we_o, data_we_o, data_rd_o}));

  // R4
  wr_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o || data_we_o) |-> !$past(stat_i[IBF_BIT]));

  // R4
  rd_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_o |-> $past(stat_i[OBF_BIT]));

  // R8
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o));

  // R8
  result_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> (!busy_o && !(done_o && err_o)));

  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R7
  refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && no_loop_i && cmd_word_i[7:0] == LOOP_OP)
      |=> (busy_o && !cmd_we_o) ##1 err_o);
endmodule

bind kbc_cmd_seq kbc_cmd_seq_chk #(
  .LOOP_OP (LOOP_OP),
  .OBF_BIT (OBF_BIT),
  .IBF_BIT (IBF_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .cmd_word_i (cmd_word_i),
  .no_loop_i  (no_loop_i),
  .stat_i     (stat_i),
  .cmd_we_o   (cmd_we_o),
  .data_we_o  (data_we_o),
  .data_rd_o  (data_rd_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/kbc_cmd_seq_test.sv
module kbc_cmd_seq_test;
  localparam int SLOTS = 15;
  localparam int TO    = 6;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0;
  logic [15:0]        cmd_word_i = '0;
  logic [SLOTS*8-1:0] param_i = '0;
  logic               no_loop_i = 1'b0;
  logic               tick_i = 1'b1;
  logic [7:0]         stat_i;
  logic [7:0]         rdata_i;
  logic               cmd_we_o, data_we_o, data_rd_o, busy_o, done_o, err_o;
  logic [7:0]         wdata_o;
  logic [SLOTS*8-1:0] buf_o;

  kbc_cmd_seq #(.SLOTS(SLOTS), .TIMEOUT_POLLS(TO)) uut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- controller port model ----------------
  logic [7:0] rsp_mem [256];
  bit         aux_mem [256];
  int rsp_head = 0, rsp_tail = 0;
  int ibf_cnt = 0, ibf_delay = 1, obf_wait = 0, obf_delay = 0;
  bit force_ibf = 0;
  int tick_div = 1;
  logic [8:0] wr_log [$];
  int rd_cnt = 0;

  logic dev_ibf, dev_obf, dev_aux;
  assign dev_ibf = force_ibf || (ibf_cnt > 0);
  assign dev_obf = (rsp_head < rsp_tail) && (obf_wait == 0);
  assign dev_aux = (rsp_head < rsp_tail) ? aux_mem[rsp_head] : 1'b0;
  assign stat_i  = {2'b00, dev_aux, 3'b000, dev_ibf, dev_obf};
  assign rdata_i = (rsp_head < rsp_tail) ? rsp_mem[rsp_head] : 8'h00;

  always @(posedge clk_i) begin
    if (cmd_we_o || data_we_o) begin
      wr_log.push_back({cmd_we_o, wdata_o});
      ibf_cnt <= ibf_delay;
    end else if (ibf_cnt > 0) ibf_cnt <= ibf_cnt - 1;
    if (data_rd_o) begin
      rd_cnt++;
      rsp_head <= rsp_head + 1;
      obf_wait <= obf_delay;
    end else if (obf_wait > 0) obf_wait <= obf_wait - 1;
  end

  always @(negedge clk_i) tick_i <= (tick_div == 1) || (cyc % tick_div == 0);

  // ---------------- behavioural reference ----------------
  localparam int K_IDLE = 0, K_REF = 1, K_WW = 2, K_PC = 3, K_PP = 4, K_WR = 5, K_GR = 6;
  int m_kind, m_step, m_polls, m_np, m_nr;
  bit m_loop, m_done, m_err;
  logic [7:0] m_op;
  logic [7:0] m_buf [SLOTS];

  task automatic m_advance();
    m_polls = 0;
    if (m_step <= m_np)             m_kind = K_WW;
    else if (m_step <= m_np + m_nr) m_kind = K_WR;
    else begin m_kind = K_IDLE; m_done = 1; end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_kind = K_IDLE; m_done = 0; m_err = 0; m_step = 0; m_polls = 0;
      for (int k = 0; k < SLOTS; k++) m_buf[k] = 8'h00;
    end else begin
      m_done = 0; m_err = 0;
      case (m_kind)
        K_IDLE: if (start_i) begin
          m_op = cmd_word_i[7:0]; m_np = cmd_word_i[15:12]; m_nr = cmd_word_i[11:8];
          for (int k = 0; k < SLOTS; k++) m_buf[k] = param_i[k*8 +: 8];
          m_loop = (m_op == 8'hD3);
          m_step = 0; m_polls = 0;
          m_kind = (no_loop_i && m_loop) ? K_REF : K_WW;
        end
        K_REF: begin m_kind = K_IDLE; m_err = 1; end
        K_WW: if (tick_i) begin
          if (!stat_i[1]) m_kind = (m_step == 0) ? K_PC : K_PP;
          else if (m_polls == TO - 1) begin m_kind = K_IDLE; m_err = 1; end
          else m_polls++;
        end
        K_WR: if (tick_i) begin
          if (stat_i[0]) begin
            if (m_loop && !stat_i[5]) begin m_kind = K_IDLE; m_err = 1; end
            else m_kind = K_GR;
          end else if (m_polls == TO - 1) begin m_kind = K_IDLE; m_err = 1; end
          else m_polls++;
        end
        K_PC, K_PP: begin m_step++; m_advance(); end
        K_GR: begin m_buf[m_step - 1 - m_np] = rdata_i; m_step++; m_advance(); end
        default: m_kind = K_IDLE;
      endcase
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    chk(busy_o == (m_kind != K_IDLE), "R8", "busy", busy_o, m_kind != K_IDLE);
    chk(cmd_we_o == (m_kind == K_PC), "R1", "cmd_we", cmd_we_o, m_kind == K_PC);
    chk(data_we_o == (m_kind == K_PP), "R2", "data_we", data_we_o, m_kind == K_PP);
    chk(data_rd_o == (m_kind == K_GR), "R4", "data_rd", data_rd_o, m_kind == K_GR);
    chk(done_o == m_done, "R9", "done", done_o, m_done);
    chk(err_o == m_err, "R5", "err", err_o, m_err);
    if (m_kind == K_PC) chk(wdata_o == m_op, "R1", "opcode", wdata_o, m_op);
    if (m_kind == K_PP) chk(wdata_o == m_buf[m_step - 1], "R2", "param", wdata_o, m_buf[m_step - 1]);
    for (int k = 0; k < SLOTS; k++)
      if (buf_o[k*8 +: 8] !== m_buf[k]) begin
        chk(0, "R3", $sformatf("slot%0d", k), buf_o[k*8 +: 8], m_buf[k]);
        break;
      end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] par_v [SLOTS];
  bit r_done, r_err;
  int r_busy;

  task automatic push_rsp(input logic [7:0] b, input bit aux);
    rsp_mem[rsp_tail] = b; aux_mem[rsp_tail] = aux; rsp_tail++;
  endtask

  task automatic prep();
    @(negedge clk_i);
    rsp_tail = rsp_head;
    wr_log.delete();
    rd_cnt = 0;
    for (int k = 0; k < SLOTS; k++) par_v[k] = 8'hA0 + 8'(k);
  endtask

  task automatic run(input logic [15:0] w);
    cmd_word_i = w;
    for (int k = 0; k < SLOTS; k++) param_i[k*8 +: 8] = par_v[k];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    r_done = 0; r_err = 0; r_busy = 0;
    for (int i = 0; i < 3000; i++) begin
      if (busy_o) r_busy++;
      if (done_o || err_o) begin r_done = done_o; r_err = err_o; break; end
      @(negedge clk_i);
    end
    @(negedge clk_i);
  endtask

  function automatic logic [7:0] slot(input int k);
    return buf_o[k*8 +: 8];
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && !cmd_we_o && !data_we_o && !data_rd_o,
        "R8", "reset outputs", {busy_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // single response read, R3 R9
    prep(); ibf_delay = 2; push_rsp(8'h47, 0);
    run(16'h0120);
    chk(r_done && !r_err, "R9", "done", r_done, 1);
    chk(r_busy == 4, "R9", "busy cycles", r_busy, 4);
    chk(slot(0) == 8'h47, "R3", "slot0", slot(0), 8'h47);
    chk(wr_log.size() == 1 && wr_log[0] == 9'h120, "R1", "write log", wr_log[0], 9'h120);

    // params then responses, R2 R3
    prep(); ibf_delay = 3; obf_delay = 2;
    par_v[0] = 8'h11; par_v[1] = 8'h22; par_v[2] = 8'h33; par_v[3] = 8'h44;
    push_rsp(8'hC1, 0); push_rsp(8'hC2, 0);
    run(16'h3260);
    chk(r_done, "R2", "done", r_done, 1);
    chk(wr_log.size() == 4, "R2", "writes", wr_log.size(), 4);
    chk(wr_log[0] == 9'h160 && wr_log[1] == 9'h011 && wr_log[2] == 9'h022 && wr_log[3] == 9'h033,
        "R2", "write order", wr_log[3], 9'h033);
    chk(slot(0) == 8'hC1 && slot(1) == 8'hC2, "R3", "rsp slots", slot(1), 8'hC2);
    chk(slot(2) == 8'h33 && slot(3) == 8'h44 && slot(14) == 8'hAE, "R3", "kept slots", slot(3), 8'h44);

    // loopback with aux flag, R6
    prep(); par_v[0] = 8'h5A; push_rsp(8'h5A, 1);
    run(16'h11D3);
    chk(r_done && slot(0) == 8'h5A, "R6", "loop ok", slot(0), 8'h5A);

    // loopback without aux flag, R6
    prep(); par_v[0] = 8'h5A; push_rsp(8'h99, 0);
    run(16'h11D3);
    chk(r_err && !r_done, "R6", "loop err", r_err, 1);
    chk(rd_cnt == 0 && slot(0) == 8'h5A, "R6", "no read", slot(0), 8'h5A);

    // refusal, R7
    prep(); no_loop_i = 1'b1;
    run(16'h11D3);
    chk(r_err && r_busy == 1, "R7", "refuse busy", r_busy, 1);
    chk(wr_log.size() == 0, "R7", "no writes", wr_log.size(), 0);
    prep(); push_rsp(8'h12, 0);
    run(16'h0120);
    chk(r_done && slot(0) == 8'h12, "R7", "other opcode", slot(0), 8'h12);
    no_loop_i = 1'b0;

    // stuck input buffer, R5
    prep(); force_ibf = 1;
    run(16'h0120);
    chk(r_err && r_busy == TO, "R5", "write timeout", r_busy, TO);
    chk(wr_log.size() == 0, "R5", "no strobe", wr_log.size(), 0);
    force_ibf = 0;

    // no response ever, R5
    prep(); ibf_delay = 1; obf_delay = 0;
    run(16'h0120);
    chk(r_err && wr_log.size() == 1 && rd_cnt == 0, "R5", "read timeout", r_err, 1);

    // sparse ticks, R4
    prep(); tick_div = 3; ibf_delay = 4; obf_delay = 3;
    par_v[0] = 8'h65; par_v[1] = 8'h66; push_rsp(8'h77, 0);
    run(16'h2160);
    chk(r_done && slot(0) == 8'h77 && slot(1) == 8'h66, "R4", "sparse ticks", slot(0), 8'h77);
    tick_div = 1;

    // start while busy ignored, R8
    prep(); ibf_delay = 1; obf_delay = 0;
    cmd_word_i = 16'h00AB; start_i = 1'b1; @(negedge clk_i);
    cmd_word_i = 16'h00AA; @(negedge clk_i); start_i = 1'b0;
    repeat (8) @(negedge clk_i);
    chk(wr_log.size() == 1 && wr_log[0] == 9'h1AB, "R8", "busy start", wr_log[0], 9'h1AB);

    // full buffer both ways, R2 R3
    prep(); ibf_delay = 1;
    for (int k = 0; k < SLOTS; k++) push_rsp(8'h80 + 8'(k), 0);
    run(16'hFF42);
    chk(r_done && wr_log.size() == 16, "R2", "full writes", wr_log.size(), 16);
    chk(slot(0) == 8'h80 && slot(14) == 8'h8E, "R3", "full reads", slot(14), 8'h8E);

    // opcode only, R1 R9
    prep();
    run(16'h00AE);
    chk(r_done && r_busy == 2 && wr_log.size() == 1, "R1", "opcode only", r_busy, 2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule